// File: doc/BRIEF.md
# DSI Command Packet Transmitter

This block sends one DSI command packet each time software asks for one. Software sets up a packet through a small write-only register port. It writes a type register that holds a packet-kind code, the virtual channel and the data type. It writes a word count register and up to four 16-bit payload words. It then writes 1 to a trigger register. The engine copies the setup at the trigger and emits the packet one byte per handshake on a valid/ready byte stream that feeds the lane logic.

A short packet carries the data identifier, two data bytes taken from payload word 0, and an error-correcting byte. A long packet carries the data identifier, a two-byte word count and the error-correcting byte. Then come up to eight payload bytes and a two-byte checksum. Triggers are ignored while a packet is in flight. A setup that cannot be sent raises an error flag instead of starting a packet.

Top module: `dsi_cmd_tx`

## Requirements
- R1: After reset, busy, tx_valid and err are all 0.
- R2: With kind code 0x10 in type bits [15:8], a trigger sends four bytes in this order: the identifier (type bits [7:0], which are virtual channel in [7:6] and data type in [5:0]), payload word 0 bits [7:0], payload word 0 bits [15:8], then the ECC byte.
- R3: The ECC byte covers the 24-bit header (identifier in bits [7:0], second byte in [15:8], third in [23:16]). Its bits [7:6] are 0. Parity bit p is the XOR of the header bits whose column code has bit p set. The column codes for header bits 0 to 23 are, in hex: 07 0B 0D 0E 13 15 16 19 1A 1C 23 25 26 29 2A 2C 31 32 34 38 1F 2F 37 3B.
- R4: With kind code 0x40, a trigger sends: identifier, word count low byte, word count high byte, ECC, then the payload bytes, then two checksum bytes. Payload word k sits at address 0x10+2k and carries payload byte 2k in bits [7:0] and byte 2k+1 in bits [15:8]. Registers: trigger 0x00, type 0x02, word count 0x04.
- R5: The checksum is a reflected CRC with polynomial 0x8408 and start value 0xFFFF. Each byte is shifted in bit 0 first, with no final inversion. The low byte is sent first. An empty payload gives 0xFFFF.
- R6: While tx_valid is 1 and tx_ready is 0, tx_data holds its value into the next cycle.
- R7: busy and tx_valid rise in the cycle after an accepted trigger. They fall in the cycle after the last byte is accepted, and only then.
- R8: A trigger while busy is ignored, including one in the same cycle as the final byte handshake. No second packet follows.
- R9: A long-kind trigger with a word count above 8 sets err and sends nothing. The next packet that starts clears err.
- R10: A trigger with a kind code other than 0x10 or 0x40 sets err and sends nothing.
- R11: Register writes during a packet do not change the packet in flight. They take effect at the next trigger.
- R12: A write to the trigger register with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 16 | Register write data |
| tx_data | output | 8 | Packet byte to the lane logic |
| tx_valid | output | 1 | tx_data holds a byte to send |
| tx_ready | input | 1 | Lane logic takes the byte this cycle |
| busy | output | 1 | A packet is in flight |
| err | output | 1 | The last refused trigger had an invalid setup |

## Verification
Two of the block's functions can land in the same cycle: a new trigger write and the handshake of the final byte of the current packet. The bench drives the trigger exactly in the cycle where the last byte is taken. It then checks that busy falls in the next cycle and that no further bytes appear. It does the same with a payload write part-way through a long packet. That packet must still carry the old payload, and the next packet must carry the new one.

// File: rtl/dsi_cmd_tx.sv
module dsi_cmd_tx #(
  parameter int ADDR_W = 8,
  parameter int PAY_WORDS = 4,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] TYPE_ADDR = 8'h02,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 8'h04,
  parameter logic [ADDR_W-1:0] PAY_ADDR = 8'h10,
  parameter logic [7:0] KIND_SHORT = 8'h10,
  parameter logic [7:0] KIND_LONG = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              busy,
  output logic              err
);
  localparam int MAX_BYTES = PAY_WORDS * 2;
  localparam int PAY_W = PAY_WORDS * 16;
  localparam int IDX_W = $clog2(MAX_BYTES + 8);
  localparam int PB_W = $clog2(MAX_BYTES);
  localparam logic [23:0] ECC_MASK [6] = '{24'hF12CB7, 24'hF2555B, 24'h749A6D,
                                            24'hB8E38E, 24'hDF03F0, 24'hEFFC00};

  logic [15:0] type_q, cnt_q;
  logic [15:0] pay_w [PAY_WORDS];
  logic [PAY_W-1:0] pay_flat;

  logic [7:0] s_di;
  logic s_long;
  logic [IDX_W-1:0] s_cnt;
  logic [PAY_W-1:0] s_pay;
  logic [IDX_W-1:0] idx;
  logic [15:0] crc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      type_q <= '0;
      cnt_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == TYPE_ADDR) type_q <= wr_data;
      if (wr_addr == CNT_ADDR) cnt_q <= wr_data;
    end

  for (genvar k = 0; k < PAY_WORDS; k++) begin : g_pay
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pay_w[k] <= '0;
      else if (wr_en && wr_addr == PAY_ADDR + ADDR_W'(2 * k)) pay_w[k] <= wr_data;
    assign pay_flat[k*16 +: 16] = pay_w[k];
  end

  wire trig = wr_en && wr_addr == TRIG_ADDR && wr_data[0] && !busy;
  wire kind_short = type_q[15:8] == KIND_SHORT;
  wire kind_long = type_q[15:8] == KIND_LONG;
  wire setup_ok = kind_short || (kind_long && cnt_q <= 16'(MAX_BYTES));
  wire go = trig && setup_ok;
  wire refuse = trig && !setup_ok;

  wire [23:0] hdr = s_long ? {8'h00, 8'(s_cnt), s_di} : {s_pay[15:0], s_di};
  logic [5:0] ecc;
  for (genvar p = 0; p < 6; p++) begin : g_ecc
    assign ecc[p] = ^(hdr & ECC_MASK[p]);
  end

  wire [IDX_W-1:0] pay_end = IDX_W'(4) + s_cnt;
  wire [IDX_W-1:0] last_idx = s_long ? pay_end + IDX_W'(1) : IDX_W'(3);
  wire in_pay = s_long && idx >= IDX_W'(4) && idx < pay_end;
  wire [IDX_W-1:0] pidx = idx - IDX_W'(4);
  wire [PB_W-1:0] pbyte = pidx[PB_W-1:0];

  always_comb begin
    if (idx < IDX_W'(4))
      case (idx[1:0])
        2'd0: tx_data = s_di;
        2'd1: tx_data = hdr[15:8];
        2'd2: tx_data = hdr[23:16];
        default: tx_data = {2'b00, ecc};
      endcase
    else if (in_pay) tx_data = s_pay[pbyte*8 +: 8];
    else if (idx == pay_end) tx_data = crc[7:0];
    else tx_data = crc[15:8];
  end

  assign tx_valid = busy;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ b[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      err <= 1'b0;
      idx <= '0;
      crc <= 16'hFFFF;
      s_di <= '0;
      s_long <= 1'b0;
      s_cnt <= '0;
      s_pay <= '0;
    end else begin
      if (go) begin
        busy <= 1'b1;
        err <= 1'b0;
        idx <= '0;
        crc <= 16'hFFFF;
        s_di <= type_q[7:0];
        s_long <= kind_long;
        s_cnt <= cnt_q[IDX_W-1:0];
        s_pay <= pay_flat;
      end else if (refuse) begin
        err <= 1'b1;
      end
      if (busy && tx_ready) begin
        idx <= idx + IDX_W'(1);
        if (in_pay) crc <= crc_step(crc, tx_data);
        if (idx == last_idx) busy <= 1'b0;
      end
    end
endmodule

module dsi_cmd_tx_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 8'h00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              trig_bit,
  input logic [7:0]        tx_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              busy,
  input logic              err
);
  logic [7:0] hs_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hs_cnt <= '0;
    else if (!busy) hs_cnt <= '0;
    else if (tx_valid && tx_ready) hs_cnt <= hs_cnt + 8'd1;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  p_ecc_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && hs_cnt == 8'd3) |-> (tx_data[7:6] == 2'b00));
  p_end_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx_valid && tx_ready));
  p_start_clears_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !err);
  p_refuse_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy);
  p_zero_trigger_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && wr_addr == TRIG_ADDR && !trig_bit) |=> !busy);
endmodule

bind dsi_cmd_tx dsi_cmd_tx_chk #(.ADDR_W(ADDR_W), .TRIG_ADDR(TRIG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .trig_bit(wr_data[0]),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .busy(busy), .err(err));

// File: tb/test_dsi_cmd_tx.sv
module test_dsi_cmd_tx;
  localparam logic [7:0] A_TRIG = 8'h00, A_TYPE = 8'h02, A_CNT = 8'h04, A_PAY = 8'h10;

  logic clk = 0, rst_n = 0, wr_en = 0, tx_ready = 0;
  logic [7:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [7:0] tx_data;
  logic tx_valid, busy, err;

  int checks = 0, errors = 0;
  logic [15:0] sh_type, sh_cnt;
  logic [15:0] sh_w [4];
  logic [7:0] exp_b [16];
  logic [7:0] got [16];
  int exp_n;
  bit exp_long;

  always #10 clk = ~clk;

  dsi_cmd_tx i_dsi_cmd_tx (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .busy(busy), .err(err));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [5:0] col(input int i);
    case (i)
      0: return 6'h07;  1: return 6'h0B;  2: return 6'h0D;  3: return 6'h0E;
      4: return 6'h13;  5: return 6'h15;  6: return 6'h16;  7: return 6'h19;
      8: return 6'h1A;  9: return 6'h1C; 10: return 6'h23; 11: return 6'h25;
      12: return 6'h26; 13: return 6'h29; 14: return 6'h2A; 15: return 6'h2C;
      16: return 6'h31; 17: return 6'h32; 18: return 6'h34; 19: return 6'h38;
      20: return 6'h1F; 21: return 6'h2F; 22: return 6'h37; default: return 6'h3B;
    endcase
  endfunction

  function automatic logic [7:0] ecc_f(input logic [23:0] h);
    logic [5:0] s;
    s = 0;
    for (int i = 0; i < 24; i++) if (h[i]) s ^= col(i);
    return {2'b00, s};
  endfunction

  function automatic logic [15:0] crc_f(input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = 8'(sh_w[k/2] >> (8 * (k % 2)));
      for (int j = 0; j < 8; j++) begin
        bit fb;
        fb = c[0] ^ b[j];
        c = c >> 1;
        if (fb) c ^= 16'h8408;
      end
    end
    return c;
  endfunction

  task automatic build();
    logic [23:0] h;
    logic [15:0] c;
    exp_long = (sh_type[15:8] == 8'h40);
    if (!exp_long) begin
      h = {sh_w[0], sh_type[7:0]};
      exp_n = 4;
    end else begin
      h = {sh_cnt, sh_type[7:0]};
      exp_n = 6 + int'(sh_cnt);
      for (int k = 0; k < int'(sh_cnt); k++) exp_b[4+k] = 8'(sh_w[k/2] >> (8 * (k % 2)));
      c = crc_f(int'(sh_cnt));
      exp_b[exp_n-2] = c[7:0];
      exp_b[exp_n-1] = c[15:8];
    end
    exp_b[0] = h[7:0];
    exp_b[1] = h[15:8];
    exp_b[2] = h[23:16];
    exp_b[3] = ecc_f(h);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a == A_TYPE) sh_type = d;
    if (a == A_CNT) sh_cnt = d;
    if (a >= A_PAY && a < A_PAY + 8) sh_w[(a - A_PAY) / 2] = d;
  endtask

  task automatic collect(input string req, input int stall, input int trig_at, input int mod_at);
    int got_n = 0;
    int cyc = 0;
    bit stalled = 0;
    bit rdy;
    logic [7:0] prev = 0;
    while (got_n < exp_n && cyc < 400) begin
      wr_en = 0;
      if (stalled) chk(tx_valid && tx_data == prev, "R6", "held byte", tx_data, prev);
      rdy = (stall == 0) || (cyc % 3 == 2);
      if (tx_valid && rdy) begin
        got[got_n] = tx_data;
        if (got_n == trig_at) begin wr_en = 1; wr_addr = A_TRIG; wr_data = 16'h0001; end
        if (got_n == mod_at) begin wr_en = 1; wr_addr = A_PAY; wr_data = 16'hFFFF; end
        got_n++;
      end
      stalled = tx_valid && !rdy;
      prev = tx_data;
      tx_ready = rdy;
      @(negedge clk);
      cyc++;
    end
    wr_en = 0;
    tx_ready = 0;
    chk(got_n == exp_n, "R7", "byte count", got_n, exp_n);
    for (int i = 0; i < exp_n; i++)
      chk(got[i] == exp_b[i],
          (i == 3) ? "R3" : (exp_long && i >= exp_n - 2) ? "R5" : req,
          $sformatf("byte %0d", i), got[i], exp_b[i]);
    chk(!busy && !tx_valid, "R7", "idle after last byte", {busy, tx_valid}, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !tx_valid && !err, "R1", "reset state", {busy, tx_valid, err}, 0);
  endtask

  task automatic t_short(input logic [15:0] ty, input logic [15:0] w0, input int stall);
    wr(A_TYPE, ty);
    wr(A_CNT, 16'h0000);
    wr(A_PAY, w0);
    build();
    wr(A_TRIG, 16'h0001);
    chk(busy && tx_valid, "R7", "busy after trigger", {busy, tx_valid}, 3);
    collect("R2", stall, -1, -1);
  endtask

  task automatic t_long(input logic [15:0] cnt, input int stall);
    wr(A_TYPE, 16'h4039);
    wr(A_CNT, cnt);
    wr(A_PAY + 0, 16'h3412);
    wr(A_PAY + 2, 16'h7856);
    wr(A_PAY + 4, 16'hBC9A);
    wr(A_PAY + 6, 16'hF0DE);
    build();
    wr(A_TRIG, 16'h0001);
    collect("R4", stall, -1, -1);
  endtask

  task automatic t_bad_count();
    wr(A_TYPE, 16'h4029);
    wr(A_CNT, 16'd9);
    wr(A_TRIG, 16'h0001);
    chk(err && !busy, "R9", "count 9 refused", {err, busy}, 2);
    repeat (3) @(negedge clk);
    chk(!tx_valid, "R9", "nothing sent", tx_valid, 0);
    wr(A_CNT, 16'd2);
    build();
    wr(A_TRIG, 16'h0001);
    chk(!err, "R9", "err cleared by start", err, 0);
    collect("R4", 0, -1, -1);
  endtask

  task automatic t_bad_kind();
    wr(A_TYPE, 16'h2005);
    wr(A_TRIG, 16'h0001);
    chk(err && !busy, "R10", "unknown kind refused", {err, busy}, 2);
    repeat (3) @(negedge clk);
    chk(!tx_valid, "R10", "nothing sent", tx_valid, 0);
  endtask

  task automatic t_busy_trigger();
    wr(A_TYPE, 16'h40C3);
    wr(A_CNT, 16'd8);
    build();
    wr(A_TRIG, 16'h0001);
    collect("R11", 0, 5, 2);
    sh_w[0] = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk(!busy && !tx_valid, "R8", "mid-flight trigger ignored", {busy, tx_valid}, 0);
    build();
    wr(A_TRIG, 16'h0001);
    collect("R11", 0, exp_n - 1, -1);
    repeat (3) @(negedge clk);
    chk(!busy && !tx_valid, "R8", "last-byte trigger ignored", {busy, tx_valid}, 0);
  endtask

  task automatic t_zero_trigger();
    wr(A_TYPE, 16'h1005);
    wr(A_TRIG, 16'h0000);
    chk(!busy, "R12", "zero trigger", busy, 0);
    repeat (3) @(negedge clk);
    chk(!tx_valid, "R12", "no bytes", tx_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    sh_type = 0; sh_cnt = 0;
    for (int k = 0; k < 4; k++) sh_w[k] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_short(16'h1055, 16'hA5B6, 0);
    t_short(16'h10C1, 16'h00FF, 1);
    t_long(16'd8, 0);
    t_long(16'd3, 1);
    t_long(16'd0, 0);
    t_bad_count();
    t_bad_kind();
    t_busy_trigger();
    t_zero_trigger();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule